// File: doc/BRIEF.md
# Bus Inactivity Power-Down Controller

This controller watches the address strobe of a host bus and powers the attached memories and logic down once the bus goes quiet. The strobe and the active-low chip select are asynchronous to the free-running timer clock, so each passes through a multi-flop synchronizer. A rising edge of the synchronized strobe counts as bus activity. An idle counter, clocked by the timer clock, counts the cycles since the last activity. When it reaches the idle limit (fifteen by default), the registered power-down output rises.

While power-down is high, the block asserts a bus-isolate output and a standby request to the memories. It also masks the downstream control lines chosen by a per-bit mask, and it drops the downstream clock enable if a clock-mask bit is set. The block returns to normal operation on any of three events: a new strobe edge, chip select going low, or reset. An enable input turns automatic power-down on or off. The downstream clock mask acts only on the enable output and never on the timer's own clock.

Top module: `idle_pd_ctrl`

## Requirements
- R1: While `en` is low, `pd` stays low and the idle count is held at zero, so after `en` rises a full idle limit of clocks must pass again before `pd` rises.
- R2: With `en` high and `cs_n` high, `pd` rises on exactly the fifteenth rising clock edge after the edge at which the activity event cleared the count, and it is still low after the fourteenth.
- R3: A rising edge on `strobe` is an activity event. The edge passes through a two-flop synchronizer and clears the count and `pd` on the third rising clock edge after `strobe` rises. A strobe held high, or a falling strobe, is not activity.
- R4: A low `cs_n` passes through a two-flop synchronizer. It clears `pd` on the third rising clock edge after it falls, and it holds the count at zero for as long as it stays low.
- R5: A high `rst` clears `pd`, `bus_iso`, `mem_stby`, the idle count and all control masking at once, without waiting for a clock edge, and sets `dclk_en` to 1.
- R6: The idle count saturates at the limit, so `pd` stays high for any length of idle time until a wake event occurs.
- R7: `bus_iso` and `mem_stby` are registered and are equal to `pd` on every cycle.
- R8: `ctl_out[i]` equals `ctl_in[i]`, except that it reads 0 while `pd` is high and `ctl_mask[i]` was 1 at the clock edge that last updated `pd`.
- R9: `dclk_en` is 0 exactly while `pd` is high and `clk_mask` was 1 at the last clock edge. The idle timer keeps counting, and `pd` still rises on time, whatever the value of `clk_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timer clock |
| rst | input | 1 | Asynchronous reset, active high; also a wake source |
| en | input | 1 | Enables automatic power-down |
| strobe | input | 1 | Asynchronous bus address strobe |
| cs_n | input | 1 | Asynchronous chip select, active low; wake source |
| ctl_in | input | N_CTL | Host control lines bound for downstream logic |
| ctl_mask | input | N_CTL | 1 = block that control line while powered down |
| clk_mask | input | 1 | 1 = drop the downstream clock enable while powered down |
| pd | output | 1 | Power-down state, registered |
| bus_iso | output | 1 | Isolates the host address/data bus from memories and logic |
| mem_stby | output | 1 | Standby request to the memories |
| ctl_out | output | N_CTL | Control lines after power-down masking |
| dclk_en | output | 1 | Enable for the gated downstream clock |

## Verification
Directed sequences place a strobe edge and then count idle clocks, checking that `pd` is still low at fourteen and high at fifteen. They separate an off-by-one count from a correct one, and a latency error in the synchronizer from a correct path. Separate sequences wake the block from power-down by a strobe edge, by a chip-select pulse and by reset, which shows that each wake path works on its own. Other sequences hold the strobe high, or toggle `en` in the middle of a count, to show that a level or a disable is not mistaken for activity. A long constrained-random run then mixes strobe pulses, chip-select pulses, enable changes, mask changes and rare resets, and compares every output on every cycle against a cycle-level model built from the requirements.

// File: rtl/pd_pkg.sv
package pd_pkg;
   localparam int unsigned PD_IDLE_LIMIT_DEF = 15;
   localparam int unsigned PD_SYNC_DEF       = 2;
   localparam int unsigned PD_NCTL_DEF       = 4;

   // Width needed to hold a count from 0 up to and including lim.
   function automatic int unsigned pd_cnt_width(input int unsigned lim);
      return $clog2(lim + 1);
   endfunction
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $fatal(1, "pd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain[0] <= RST_VAL;
            else     chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain[i] <= RST_VAL;
            else     chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pd_idle_timer.sv
module pd_idle_timer #(
   parameter int unsigned IDLE_LIMIT = pd_pkg::PD_IDLE_LIMIT_DEF,
   parameter int unsigned CNT_W      = pd_pkg::pd_cnt_width(IDLE_LIMIT)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             stb_s,
   input  logic             cs_s,
   output logic             act_evt,
   output logic [CNT_W-1:0] cnt,
   output logic             pd_nxt
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(IDLE_LIMIT);

   if (IDLE_LIMIT < 2) begin : g_bad_limit
      $fatal(1, "pd_idle_timer: IDLE_LIMIT must be at least 2");
   end

   logic             stb_d;
   logic             wake;
   logic [CNT_W-1:0] cnt_nxt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) stb_d <= 1'b0;
      else     stb_d <= stb_s;
   end

   assign act_evt = stb_s & ~stb_d;
   assign wake    = act_evt | ~cs_s;

   always_comb begin
      if (!en || wake)    cnt_nxt = '0;
      else if (cnt == LIM) cnt_nxt = cnt;
      else                 cnt_nxt = cnt + 1'b1;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt_nxt;
   end

   assign pd_nxt = (cnt_nxt == LIM);
endmodule

// File: rtl/pd_gate.sv
module pd_gate #(
   parameter int unsigned N_CTL = pd_pkg::PD_NCTL_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pd_nxt,
   input  logic [N_CTL-1:0] ctl_in,
   input  logic [N_CTL-1:0] ctl_mask,
   input  logic             clk_mask,
   output logic             pd,
   output logic             bus_iso,
   output logic             mem_stby,
   output logic [N_CTL-1:0] ctl_out,
   output logic             dclk_en
);
   if (N_CTL < 1) begin : g_bad_nctl
      $fatal(1, "pd_gate: N_CTL must be at least 1");
   end

   logic [N_CTL-1:0] blk;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         pd       <= 1'b0;
         bus_iso  <= 1'b0;
         mem_stby <= 1'b0;
         dclk_en  <= 1'b1;
      end else begin
         pd       <= pd_nxt;
         bus_iso  <= pd_nxt;
         mem_stby <= pd_nxt;
         dclk_en  <= ~(pd_nxt & clk_mask);
      end
   end

   for (genvar i = 0; i < N_CTL; i++) begin : g_ctl
      always_ff @(posedge clk or posedge rst) begin
         if (rst) blk[i] <= 1'b0;
         else     blk[i] <= pd_nxt & ctl_mask[i];
      end
      assign ctl_out[i] = ctl_in[i] & ~blk[i];
   end
endmodule

// File: rtl/idle_pd_ctrl.sv
module idle_pd_ctrl #(
   parameter int unsigned IDLE_LIMIT  = pd_pkg::PD_IDLE_LIMIT_DEF,
   parameter int unsigned SYNC_STAGES = pd_pkg::PD_SYNC_DEF,
   parameter int unsigned N_CTL       = pd_pkg::PD_NCTL_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             strobe,
   input  logic             cs_n,
   input  logic [N_CTL-1:0] ctl_in,
   input  logic [N_CTL-1:0] ctl_mask,
   input  logic             clk_mask,
   output logic             pd,
   output logic             bus_iso,
   output logic             mem_stby,
   output logic [N_CTL-1:0] ctl_out,
   output logic             dclk_en
);
   localparam int unsigned CNT_W = pd_pkg::pd_cnt_width(IDLE_LIMIT);

   logic             stb_s;
   logic             cs_s;
   logic             act_evt;
   logic             pd_nxt;
   logic [CNT_W-1:0] idle_cnt;

   pd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stb_sync (
      .clk(clk), .rst(rst), .d(strobe), .q(stb_s)
   );

   pd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst(rst), .d(cs_n), .q(cs_s)
   );

   pd_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT), .CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst(rst), .en(en), .stb_s(stb_s), .cs_s(cs_s),
      .act_evt(act_evt), .cnt(idle_cnt), .pd_nxt(pd_nxt)
   );

   pd_gate #(.N_CTL(N_CTL)) u_gate (
      .clk(clk), .rst(rst), .pd_nxt(pd_nxt), .ctl_in(ctl_in),
      .ctl_mask(ctl_mask), .clk_mask(clk_mask), .pd(pd),
      .bus_iso(bus_iso), .mem_stby(mem_stby), .ctl_out(ctl_out),
      .dclk_en(dclk_en)
   );
endmodule

// File: rtl/idle_pd_chk.sv
module idle_pd_chk #(
   parameter int unsigned IDLE_LIMIT = 15,
   parameter int unsigned N_CTL      = 4,
   parameter int unsigned CNT_W      = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic             pd,
   input logic             bus_iso,
   input logic             mem_stby,
   input logic [N_CTL-1:0] ctl_in,
   input logic [N_CTL-1:0] ctl_out,
   input logic             dclk_en,
   input logic             act_evt,
   input logic             cs_s,
   input logic [CNT_W-1:0] cnt
);
   assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      !en |=> !pd);

   assert_rise_at_limit_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(pd) |-> $past(cnt) == CNT_W'(IDLE_LIMIT - 1));

   assert_strobe_wakes_R3: assert property (@(posedge clk) disable iff (rst)
      act_evt |=> !pd);

   assert_cs_wakes_R4: assert property (@(posedge clk) disable iff (rst)
      !cs_s |=> !pd);

   assert_count_saturates_R6: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(IDLE_LIMIT));

   assert_iso_follows_R7: assert property (@(posedge clk) disable iff (rst)
      (bus_iso == pd) && (mem_stby == pd));

   assert_ctl_pass_R8: assert property (@(posedge clk) disable iff (rst)
      !pd |-> ctl_out == ctl_in);

   assert_clk_on_R9: assert property (@(posedge clk) disable iff (rst)
      !pd |-> dclk_en);
endmodule

bind idle_pd_ctrl idle_pd_chk #(.IDLE_LIMIT(IDLE_LIMIT), .N_CTL(N_CTL), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .en(en), .pd(pd), .bus_iso(bus_iso),
   .mem_stby(mem_stby), .ctl_in(ctl_in), .ctl_out(ctl_out),
   .dclk_en(dclk_en), .act_evt(act_evt), .cs_s(cs_s), .cnt(idle_cnt)
);

// File: tb/idle_pd_ctrl_test.sv
module idle_pd_ctrl_test;
   localparam int LIM = 15;
   localparam int NC  = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en = 1'b1;
   logic          strobe = 1'b0;
   logic          cs_n = 1'b1;
   logic [NC-1:0] ctl_in = '0;
   logic [NC-1:0] ctl_mask = '0;
   logic          clk_mask = 1'b0;
   logic          pd, bus_iso, mem_stby, dclk_en;
   logic [NC-1:0] ctl_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   idle_pd_ctrl #(.IDLE_LIMIT(LIM), .SYNC_STAGES(2), .N_CTL(NC)) uut (
      .clk(clk), .rst(rst), .en(en), .strobe(strobe), .cs_n(cs_n),
      .ctl_in(ctl_in), .ctl_mask(ctl_mask), .clk_mask(clk_mask), .pd(pd),
      .bus_iso(bus_iso), .mem_stby(mem_stby), .ctl_out(ctl_out),
      .dclk_en(dclk_en)
   );

   always #5 clk = ~clk;

   // Reference model built from the requirements (2-flop sync, edge detect,
   // saturating idle count, registered outputs).
   logic [1:0]    m_s = '0, m_c = 2'b11;
   logic          m_sd = 1'b0;
   int            m_cnt = 0;
   logic          m_pd = 1'b0, m_dclk = 1'b1;
   logic [NC-1:0] m_blk = '0;

   function automatic int next_count(int c, bit e, bit act, bit csl);
      if (!e || act || !csl) return 0;
      return (c >= LIM) ? LIM : c + 1;
   endfunction

   always @(posedge clk or posedge rst) begin
      if (rst) begin
         m_s <= '0; m_c <= 2'b11; m_sd <= 1'b0; m_cnt <= 0;
         m_pd <= 1'b0; m_dclk <= 1'b1; m_blk <= '0;
      end else begin
         int n;
         n = next_count(m_cnt, en, m_s[1] & ~m_sd, m_c[1]);
         m_s <= {m_s[0], strobe};
         m_sd <= m_s[1];
         m_c <= {m_c[0], cs_n};
         m_cnt <= n;
         m_pd <= (n == LIM);
         m_dclk <= ~((n == LIM) & clk_mask);
         m_blk <= {NC{n == LIM}} & ctl_mask;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   task automatic cmp_model();
      chk("R2 pd vs model", 32'(pd), 32'(m_pd));
      chk("R7 bus_iso", 32'(bus_iso), 32'(m_pd));
      chk("R7 mem_stby", 32'(mem_stby), 32'(m_pd));
      chk("R8 ctl_out", 32'(ctl_out), 32'(ctl_in & ~m_blk));
      chk("R9 dclk_en", 32'(dclk_en), 32'(m_dclk));
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cycles++;
         cmp_model();
      end
   endtask

   // Pulse strobe for one cycle; return after the given number of negedges
   // counted from the one where strobe was driven high.
   task automatic pulse_then(input int n);
      strobe = 1'b1;
      tick(1);
      strobe = 1'b0;
      tick(n - 1);
   endtask

   always @(posedge clk) begin
      if (!done && cycles > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      tick(2);
      chk("R5 reset pd", 32'(pd), 0);
      chk("R5 reset dclk_en", 32'(dclk_en), 1);
      chk("R5 reset bus_iso", 32'(bus_iso), 0);
      rst = 1'b0;
      tick(3);

      // R2: exact idle limit
      pulse_then(17);
      chk("R2 low after 14 idle", 32'(pd), 0);
      tick(1);
      chk("R2 high after 15 idle", 32'(pd), 1);
      chk("R7 iso with pd", 32'(bus_iso & mem_stby), 1);

      // R6: saturation
      tick(40);
      chk("R6 pd held", 32'(pd), 1);

      // R3: strobe wake on third edge
      strobe = 1'b1;
      tick(2);
      chk("R3 pd before sync", 32'(pd), 1);
      tick(1);
      chk("R3 pd woken", 32'(pd), 0);
      // R3: level held high is not activity
      tick(14);
      chk("R3 held high counts idle 14", 32'(pd), 0);
      tick(1);
      chk("R3 held high counts idle 15", 32'(pd), 1);
      strobe = 1'b0;
      tick(5);
      chk("R3 falling edge not activity", 32'(pd), 1);

      // R4: chip select wake and hold
      cs_n = 1'b0;
      tick(2);
      chk("R4 pd before sync", 32'(pd), 1);
      tick(1);
      chk("R4 pd woken", 32'(pd), 0);
      tick(30);
      chk("R4 held normal", 32'(pd), 0);
      cs_n = 1'b1;
      tick(40);
      chk("R4 idle again after release", 32'(pd), 1);

      // R5: async reset wake
      @(negedge clk);
      rst = 1'b1;
      #1;
      chk("R5 async clear pd", 32'(pd), 0);
      tick(2);
      rst = 1'b0;
      tick(20);

      // R1: disable mid count
      pulse_then(10);
      en = 1'b0;
      tick(30);
      chk("R1 disabled no pd", 32'(pd), 0);
      en = 1'b1;
      tick(15);
      chk("R1 full limit again 15", 32'(pd), 1);
      pulse_then(17);
      en = 1'b0; tick(1); en = 1'b1;
      tick(14);
      chk("R1 restart 14", 32'(pd), 0);
      tick(1);
      chk("R1 restart 15", 32'(pd), 1);

      // R8/R9: masking while powered down, timer still runs with clk_mask
      ctl_mask = 4'b0101; clk_mask = 1'b1; ctl_in = 4'hF;
      pulse_then(18);
      chk("R9 pd rises with clk_mask", 32'(pd), 1);
      chk("R9 dclk_en low", 32'(dclk_en), 0);
      chk("R8 masked ctl", 32'(ctl_out), 32'h0A);

      // Random phase
      for (int k = 0; k < 4000; k++) begin
         if ($urandom_range(0, 24) == 0) strobe = ~strobe;
         if ($urandom_range(0, 60) == 0) cs_n = ~cs_n;
         else if (!cs_n && $urandom_range(0, 3) == 0) cs_n = 1'b1;
         if ($urandom_range(0, 80) == 0) en = ~en;
         else if (!en && $urandom_range(0, 5) == 0) en = 1'b1;
         ctl_in = NC'($urandom);
         if ($urandom_range(0, 30) == 0) ctl_mask = NC'($urandom);
         if ($urandom_range(0, 30) == 0) clk_mask = 1'($urandom);
         rst = ($urandom_range(0, 400) == 0);
         tick(1);
      end
      rst = 1'b0;
      tick(2);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule